// File: doc/BRIEF.md
# Quasi-resonant switching cycle sequencer

This block produces the gate-drive pulse of a converter that runs in critical conduction mode. It works only on digitised comparator levels: a sense-above-arm level, a sense-below-trigger level, a peak-current level and an on-time-ramp-reached level. From these it decides, cycle by cycle, when the power switch turns on and when it turns off.

A pulse ends on whichever comes first: the on-time ramp reaching its target, or a peak-current trip once the leading-edge blank is over. The next pulse starts on a valley, which is detected as an armed falling transition of the sense signal. The detector is armed by a rising transition during the off-time. A valley found too early, inside the minimum off-time blank, is remembered and acted on when the blank ends. When no valley comes, a watchdog restarts switching. A fault-mode input stretches the watchdog timeout. All durations are parameters counted in clock cycles. The defaults assume a 10 MHz clock: 3 cycles of blank, 20 cycles of minimum off-time, and watchdogs of 2000 and 12500 cycles.

Top module: `qr_cycle_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, or `en` is low at a clock edge, `drv` is low in the next cycle and every timer, flag and remembered trigger is cleared. The first cycle with `en` high starts a fresh off phase, with the off-time index and the watchdog count both at 0.
- R2: A cycle with `drv` high and `ton_done` high is followed by a cycle with `drv` low.
- R3: Cycles of a pulse are indexed from 0 at its first high cycle. A cycle with `drv` high, `ipk_trip` high and an index of at least `LEB_CYC` is followed by a cycle with `drv` low.
- R4: `ipk_trip` has no effect in pulse cycles whose index is below `LEB_CYC`. A pulse with `ipk_trip` held high from its first cycle and `ton_done` low therefore lasts exactly `LEB_CYC+1` cycles.
- R5: The arm flag is set by a 0-to-1 transition of `sense_arm` seen while `drv` is low. A high `sense_arm` in the first low cycle counts as such a transition, and a transition seen while `drv` is high is ignored. The flag is cleared when `drv` rises. A valley is a 0-to-1 transition of `sense_trig` in a low cycle with the flag already set; a transition in the same cycle as the arming edge, or with no arming edge, does not start a pulse.
- R6: Low cycles are indexed from 0 at the first low cycle. A valley at an index of at least `MIN_OFF_CYC` makes `drv` high in the next cycle.
- R7: A valley at an index below `MIN_OFF_CYC` is remembered, and `drv` then stays low for exactly `MIN_OFF_CYC+1` cycles.
- R8: The watchdog count clears in the first high cycle of each pulse. It then adds one in every cycle with `sense_arm` low, in both phases. In a low cycle at an index of at least `MIN_OFF_CYC`, with `sense_arm` low and the count at least the limit minus 1, `drv` is high in the next cycle. The limit is `WD_CYC` when `fault_mode` is low, so with `sense_arm` low and no valley, pulses start every `WD_CYC` cycles.
- R9: The watchdog count holds its value in every cycle with `sense_arm` high. Each such cycle delays a watchdog restart by one cycle.
- R10: While `fault_mode` is high, the watchdog limit is `WD_FAULT_CYC` instead of `WD_CYC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global enable; low forces the drive off and clears all timers |
| sense_arm | input | 1 | Sense signal is above the arming level |
| sense_trig | input | 1 | Sense signal is below the valley trigger level |
| ipk_trip | input | 1 | Switch current has reached the peak limit |
| ton_done | input | 1 | On-time ramp has reached the feedback level |
| fault_mode | input | 1 | Selects the long watchdog timeout |
| drv | output | 1 | Gate-drive command, registered |

## Verification
The closest coincidence is a valley that lands on the very cycle the minimum off-time blank expires, or in the same cycle as its own arming edge. The first must start a pulse at once and the second must fall back to the watchdog. The bench places trigger edges at, just before and just after index `MIN_OFF_CYC`, and places an arming edge and a trigger edge together. It judges each case by the measured low-time and by a cycle-level reference model. A second collision is a peak trip landing on the cycle the blank ends while the ramp signal is due. Directed cases at index `LEB_CYC` and random stimulus cover it.

// File: rtl/qr_pkg.sv
// Package qr_pkg
// Shared types for the quasi-resonant sequencer: switching phase and the
// pair of digitised sense levels handed to the valley detector.
package qr_pkg;

    typedef enum logic {
        PH_OFF = 1'b0,
        PH_ON  = 1'b1
    } phase_e;

    typedef struct packed {
        logic arm;   // sense above arming level
        logic trig;  // sense below trigger level
    } sense_t;

endpackage

// File: rtl/qr_zcd_arm.sv
// Module qr_zcd_arm
// Valley detector. It arms on a rising edge of the arm level taken during
// the off phase and reports a valley on a rising edge of the below-trigger
// level once armed. Assumes inputs are already synchronised to clk. The
// edge history of the arm level is forced low during the on phase, so a
// level that is already high when the drive falls counts as an edge.
module qr_zcd_arm (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  qr_pkg::phase_e phase,
    input  logic           start,
    input  qr_pkg::sense_t sense,
    output logic           valley
);
    logic prev_arm;
    logic prev_trig;
    logic armed;
    logic arm_edge;

    assign arm_edge = (phase == qr_pkg::PH_OFF) && sense.arm && !prev_arm;
    assign valley   = (phase == qr_pkg::PH_OFF) && armed && sense.trig && !prev_trig;

    // Edge history and arm flag; cleared by reset, by disable and on pulse start.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            prev_arm  <= 1'b0;
            prev_trig <= 1'b0;
            armed     <= 1'b0;
        end else begin
            prev_trig <= sense.trig;
            prev_arm  <= (phase == qr_pkg::PH_ON) ? 1'b0 : sense.arm;
            if (start) begin
                armed <= 1'b0;
            end else if (arm_edge) begin
                armed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/qr_on_timer.sv
// Module qr_on_timer
// On-phase timing. It counts cycles since the drive rose and raises stop
// when the ramp is done or when a peak trip arrives after the leading-edge
// blank. Assumes the count restarts in the first high cycle of each pulse.
module qr_on_timer #(
    parameter int LEB_CYC = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  qr_pkg::phase_e phase,
    input  logic           ton_done,
    input  logic           ipk_trip,
    output logic           stop
);
    localparam int LW = $clog2(LEB_CYC + 1) + 1;
    localparam logic [LW-1:0] LEB_L = LW'(LEB_CYC);

    logic [LW-1:0] on_cnt;
    logic          blank_over;

    assign blank_over = (on_cnt >= LEB_L);
    assign stop = (phase == qr_pkg::PH_ON) && (ton_done || (ipk_trip && blank_over));

    // Saturating count of on-phase cycles; zero whenever the drive is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            on_cnt <= '0;
        end else if (phase == qr_pkg::PH_OFF) begin
            on_cnt <= '0;
        end else if (!blank_over) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/qr_off_timer.sv
// Module qr_off_timer
// Off-phase timing. It holds the minimum off-time blank, the remembered
// early valley and the watchdog, and raises start when a pulse may begin.
// Assumes the watchdog count restarts at each pulse start, counts in both
// phases and pauses while the arm level is high.
module qr_off_timer #(
    parameter int MIN_OFF_CYC  = 20,
    parameter int WD_CYC       = 2000,
    parameter int WD_FAULT_CYC = 12500
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  qr_pkg::phase_e phase,
    input  logic           valley,
    input  logic           sense_arm,
    input  logic           fault_mode,
    output logic           start
);
    localparam int WD_MAX = (WD_FAULT_CYC > WD_CYC) ? WD_FAULT_CYC : WD_CYC;
    localparam int WW     = $clog2(WD_MAX + 1);
    localparam int OW     = $clog2(MIN_OFF_CYC + 1) + 1;
    localparam logic [OW-1:0] MIN_OFF_L = OW'(MIN_OFF_CYC);
    localparam logic [WW-1:0] WD_LIM_N  = WW'(WD_CYC - 1);
    localparam logic [WW-1:0] WD_LIM_F  = WW'(WD_FAULT_CYC - 1);
    localparam logic [WW-1:0] WD_SAT    = WW'(WD_MAX - 1);

    logic [OW-1:0] off_cnt;
    logic [WW-1:0] wd_cnt;
    logic [WW-1:0] wd_lim;
    logic          pending;
    logic          blank_done;
    logic          wd_expired;

    assign wd_lim     = fault_mode ? WD_LIM_F : WD_LIM_N;
    assign blank_done = (off_cnt >= MIN_OFF_L);
    assign wd_expired = !sense_arm && (wd_cnt >= wd_lim);
    assign start      = (phase == qr_pkg::PH_OFF) && blank_done &&
                        (valley || pending || wd_expired);

    // Saturating count of off-phase cycles; zero while the drive is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            off_cnt <= '0;
        end else if (phase == qr_pkg::PH_ON) begin
            off_cnt <= '0;
        end else if (!blank_done) begin
            off_cnt <= off_cnt + 1'b1;
        end
    end

    // Watchdog count: cleared on pulse start, paused while arm level is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            wd_cnt <= '0;
        end else if (start) begin
            wd_cnt <= '0;
        end else if (!sense_arm && (wd_cnt < WD_SAT)) begin
            wd_cnt <= wd_cnt + 1'b1;
        end
    end

    // Remembers a valley seen inside the blank until the pulse it causes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pending <= 1'b0;
        end else if (start) begin
            pending <= 1'b0;
        end else if (valley) begin
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/qr_cycle_seq.sv
// Module qr_cycle_seq
// Top of the quasi-resonant switching sequencer. It owns the registered
// drive and connects the valley detector and the on and off timers.
// Assumes all comparator inputs are synchronous to clk. Durations are in
// clock cycles; the defaults suit a 10 MHz clock.
module qr_cycle_seq #(
    parameter int LEB_CYC      = 3,
    parameter int MIN_OFF_CYC  = 20,
    parameter int WD_CYC       = 2000,
    parameter int WD_FAULT_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sense_arm,
    input  logic sense_trig,
    input  logic ipk_trip,
    input  logic ton_done,
    input  logic fault_mode,
    output logic drv
);
    logic           drv_q;
    logic           start;
    logic           stop;
    logic           valley;
    qr_pkg::phase_e phase;
    qr_pkg::sense_t sense;

    assign phase      = drv_q ? qr_pkg::PH_ON : qr_pkg::PH_OFF;
    assign sense.arm  = sense_arm;
    assign sense.trig = sense_trig;
    assign drv        = drv_q;

    qr_zcd_arm i_zcd (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .phase  (phase),
        .start  (start),
        .sense  (sense),
        .valley (valley)
    );

    qr_on_timer #(
        .LEB_CYC (LEB_CYC)
    ) i_on (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .phase    (phase),
        .ton_done (ton_done),
        .ipk_trip (ipk_trip),
        .stop     (stop)
    );

    qr_off_timer #(
        .MIN_OFF_CYC  (MIN_OFF_CYC),
        .WD_CYC       (WD_CYC),
        .WD_FAULT_CYC (WD_FAULT_CYC)
    ) i_off (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .phase      (phase),
        .valley     (valley),
        .sense_arm  (sense_arm),
        .fault_mode (fault_mode),
        .start      (start)
    );

    // Drive register: forced low when disabled, toggled by stop and start.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            drv_q <= 1'b0;
        end else begin
            case (phase)
                qr_pkg::PH_ON:  if (stop)  drv_q <= 1'b0;
                qr_pkg::PH_OFF: if (start) drv_q <= 1'b1;
                default:        drv_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/qr_cycle_seq_chk.sv
// Module qr_cycle_seq_chk
// Property checker for qr_cycle_seq. It sees only the top-level ports and
// keeps its own counts of high and low drive cycles.
module qr_cycle_seq_chk #(
    parameter int LEB_CYC     = 3,
    parameter int MIN_OFF_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic ipk_trip,
    input logic ton_done,
    input logic drv
);
    localparam int HW = $clog2(LEB_CYC + 1) + 1;
    localparam int LW = $clog2(MIN_OFF_CYC + 2) + 1;
    localparam logic [HW-1:0] LEB_L  = HW'(LEB_CYC);
    localparam logic [LW-1:0] MINL_L = LW'(MIN_OFF_CYC + 1);

    logic [HW-1:0] hi_cnt;
    logic [LW-1:0] lo_cnt;

    // Index of the current high cycle, saturating at the blank length.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !drv) begin
            hi_cnt <= '0;
        end else if (hi_cnt < LEB_L) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // Number of low cycles before the current one, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || drv) begin
            lo_cnt <= '0;
        end else if (lo_cnt < MINL_L) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    p_disable_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !drv);

    p_rise_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv) |-> $past(en));

    p_ramp_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (drv && ton_done) |=> !drv);

    p_trip_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv && ipk_trip && (hi_cnt >= LEB_L)) |=> !drv);

    p_trip_blanked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && drv && ipk_trip && !ton_done && (hi_cnt < LEB_L)) |=> drv);

    p_min_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv) |-> (lo_cnt >= MINL_L));

endmodule

bind qr_cycle_seq qr_cycle_seq_chk #(
    .LEB_CYC     (LEB_CYC),
    .MIN_OFF_CYC (MIN_OFF_CYC)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ipk_trip (ipk_trip),
    .ton_done (ton_done),
    .drv      (drv)
);

// File: tb/test_qr_cycle_seq.sv
// Bench for qr_cycle_seq: directed pulse and off-time cases plus seeded
// random stimulus, judged by measured durations and a cycle-level model.
module test_qr_cycle_seq;
    localparam int LEB   = 3;
    localparam int MINOFF = 8;
    localparam int WD    = 40;
    localparam int WDF   = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic sa = 1'b0;
    logic st = 1'b0;
    logic ip = 1'b0;
    logic td = 1'b1;
    logic fm = 1'b0;
    logic drv;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    // reference model state
    bit m_drv, m_arm, m_pend, m_pa, m_pt;
    int m_on, m_off, m_wd;

    always #5 clk = ~clk;

    qr_cycle_seq #(
        .LEB_CYC      (LEB),
        .MIN_OFF_CYC  (MINOFF),
        .WD_CYC       (WD),
        .WD_FAULT_CYC (WDF)
    ) i_qr_cycle_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .sense_arm  (sa),
        .sense_trig (st),
        .ipk_trip   (ip),
        .ton_done   (td),
        .fault_mode (fm),
        .drv        (drv)
    );

    // Next state of the reference model from the inputs sampled at this edge.
    task automatic model_step();
        int lim;
        bit vly, aedge, wexp, go;
        if (!rst_n || !en) begin
            m_drv = 0; m_arm = 0; m_pend = 0; m_pa = 0; m_pt = 0;
            m_on = 0; m_off = 0; m_wd = 0;
            return;
        end
        lim = fm ? WDF - 1 : WD - 1;
        if (m_drv) begin
            if (!sa) m_wd++;
            m_pt = st;
            m_pa = 0;
            if (td || (ip && m_on >= LEB)) begin
                m_drv = 0;
                m_off = 0;
            end else begin
                m_on++;
            end
        end else begin
            vly   = m_arm && st && !m_pt;
            aedge = sa && !m_pa;
            wexp  = !sa && (m_wd >= lim);
            go    = (m_off >= MINOFF) && (vly || m_pend || wexp);
            m_pt = st;
            m_pa = sa;
            if (go) begin
                m_drv = 1; m_on = 0; m_wd = 0; m_arm = 0; m_pend = 0;
            end else begin
                if (aedge) m_arm = 1;
                if (vly) m_pend = 1;
                if (!sa) m_wd++;
            end
            m_off++;
        end
    endtask

    // One clock: sample after the edge and compare with the model.
    task automatic cyc();
        @(posedge clk);
        #1;
        model_step();
        vectors++;
        if (drv !== m_drv) begin
            fails++;
            $display("FAIL %s: drv actual %0b expected %0b at %0t", cur_req, drv, m_drv, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Measure a low phase with a scripted sense pattern by low-cycle index.
    task automatic run_off(input bit arm_in_on, input int arm_at, input int hf,
                           input int hl, input int trig_at, input int exp,
                           input string req);
        int idx;
        cur_req = req;
        td = 1'b1; ip = 1'b0; st = 1'b0; sa = 1'b0;
        while (!drv) cyc();
        sa = arm_in_on;
        while (drv) cyc();
        idx = 0;
        forever begin
            sa = (idx == arm_at) || (idx >= hf && idx < hf + hl);
            st = (trig_at >= 0) && (idx >= trig_at);
            cyc();
            if (drv || idx > 4000) break;
            idx++;
        end
        check_int(req, idx + 1, exp);
        sa = 1'b0; st = 1'b0;
    endtask

    // Measure the length of a pulse with scripted trip and ramp inputs.
    task automatic run_on(input int ip_at, input int td_at, input int exp,
                          input string req);
        int idx;
        cur_req = req;
        sa = 1'b0; st = 1'b0; ip = 1'b0; td = 1'b1;
        while (drv) cyc();
        td = 1'b0;
        while (!drv) cyc();
        idx = 0;
        forever begin
            ip = (idx >= ip_at);
            td = (idx >= td_at);
            cyc();
            if (!drv || idx > 4000) break;
            idx++;
        end
        check_int(req, idx + 1, exp);
        ip = 1'b0; td = 1'b1;
    endtask

    // Watchdog for a hung run.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int idx;
        int seed;
        seed = 32'h5eed_0017;
        void'($urandom(seed));

        // R1: reset state
        cur_req = "R1";
        repeat (3) cyc();
        check_int("R1 reset drv", int'(drv), 0);
        en = 1'b1;
        rst_n = 1'b1;

        // R2 ramp ends pulse
        run_on(999, 0, 1, "R2");
        run_on(999, 7, 8, "R2");
        run_on(1, 2, 3, "R2");
        // R4 trip during blank ignored, R3 trip after blank honoured
        run_on(0, 999, LEB + 1, "R4");
        run_on(LEB - 1, 999, LEB + 1, "R4");
        run_on(LEB, 999, LEB + 1, "R3");
        run_on(5, 999, 6, "R3");
        run_on(LEB, LEB, LEB + 1, "R3");

        // R8 plain watchdog period with a one-cycle pulse
        run_off(0, -1, 999, 0, -1, WD - 1, "R8");
        // R6 valley after blank, including on the expiry cycle
        run_off(0, 2, 999, 0, 15, 16, "R6");
        run_off(0, 0, 999, 0, MINOFF, MINOFF + 1, "R6");
        // R7 valley inside the blank remembered
        run_off(0, 1, 999, 0, 4, MINOFF + 1, "R7");
        run_off(0, 1, 999, 0, MINOFF - 1, MINOFF + 1, "R7");
        // R5 no arm, arm in same cycle, arm only during the pulse
        run_off(0, -1, 999, 0, 3, WD - 1, "R5");
        run_off(0, 5, 999, 0, 5, WD, "R5");
        run_off(1, -1, 999, 0, 12, WD, "R5");
        // R9 watchdog paused while the arm level is high
        run_off(0, -1, 5, 20, -1, WD - 1 + 20, "R9");
        // R10 long watchdog in fault mode
        fm = 1'b1;
        run_off(0, -1, 999, 0, -1, WDF - 1, "R10");
        fm = 1'b0;
        run_off(0, -1, 999, 0, -1, WD - 1, "R10");

        // R1 disable during a pulse, then fresh watchdog after enable
        cur_req = "R1";
        td = 1'b1;
        while (drv) cyc();
        td = 1'b0;
        while (!drv) cyc();
        en = 1'b0;
        cyc();
        check_int("R1 disable drv", int'(drv), 0);
        cyc();
        cyc();
        en = 1'b1;
        td = 1'b1;
        idx = 0;
        forever begin
            cyc();
            if (drv || idx > 4000) break;
            idx++;
        end
        check_int("R1 re-enable low time", idx + 1, WD);

        // random stimulus judged by the model every cycle
        cur_req = "R3/R5/R6/R7/R9 random";
        for (int n = 0; n < 6000; n++) begin
            en = ($urandom_range(0, 199) != 0);
            sa = ($urandom_range(0, 3) == 0);
            st = ($urandom_range(0, 2) == 0);
            ip = ($urandom_range(0, 3) == 0);
            td = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 299) == 0) fm = ~fm;
            cyc();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule